// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-driven station-management master. It builds Clause 22 and Clause 45 management frames and shifts them out to external PHYs. It also captures the 16-bit answer to a read. Software talks to it through a small 32-bit register port with four word registers. On the line side it drives a management clock and a three-state data line, which appears as separate out, output-enable and in signals.

Register writes are the only way to start a bus transaction. Writing the data register sends a write frame. In Clause 45 mode, writing the address register sends an address frame. Writing the control register with its read bit set sends a read frame. One configuration bit picks the framing. A second configuration bit picks the management-clock edge on which the master changes the data line. A 16-bit divider sets the clock rate. Software polls a busy flag and checks an error flag that marks a read nobody answered.

Register map, selected by `addr`:
- 0 is configuration and status.
- 1 is control.
- 2 is address.
- 3 is data.

Top module: `mdio_master`

## Requirements
- R1: After reset, register 0 reads 0x0000_0008: neg bit 3 is set, divider [31:16] is 0, and clause bit 2, error bit 1 and busy bit 0 are all clear. MDC is low and MDIO output-enable is low.
- R2: With divider value D > 0, MDC stays high for D clock cycles and low for D clock cycles. With D = 0, MDC is held low.
- R3: Every frame is 64 bits, sent MSB first. The fields in order are: 32 ones, 2-bit start, 2-bit opcode, 5-bit port, 5-bit device/register, 2-bit turnaround, 16-bit data. In Clause 22 mode (bit 2 clear) the start code is 01, write uses opcode 01 and read uses opcode 10. The port field comes from control [9:5] and the device/register field from control [4:0].
- R4: In Clause 45 mode (bit 2 set) the start code is 00 and the opcodes are address 00, write 01 and read 11. Writing register 2 sends an address frame carrying wdata[15:0]. In Clause 22 mode, writing register 2 only stores the value and sends no frame.
- R5: Writing register 3 sends a write frame with turnaround 10 and data wdata[15:0]. Output-enable stays high for all 64 bits.
- R6: Writing register 1 with bit 15 set sends a read frame that uses the port and device fields of the same write. From bit 46 (the first turnaround bit) onward the master releases MDIO. It samples the 16 data bits on rising MDC edges, and register 3 [15:0] holds them once busy clears.
- R7: If MDIO is not low during the second turnaround bit of a read, error bit 1 is set and register 3 reads 0xFFFF. Starting any later frame clears the error bit.
- R8: Busy bit 0 reads 1 from the clock after a frame-starting write until the frame ends, and reads 0 otherwise.
- R9: While busy is 1, every register write is ignored. No frame starts and no stored value changes.
- R10: With neg bit 3 set, MDIO output changes only just after a falling MDC edge. With it clear, MDIO output changes only just after a rising MDC edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the selected register (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
On every cycle, the assertions check four things. Output-enable is low whenever no frame is running and throughout the turnaround and data phase of a read. Stored control fields hold steady across writes made while busy. A stopped divider keeps MDC low. MDIO output only moves together with an MDC edge. The frame contents, the divider period and the read data cannot be seen by a per-cycle property, so only the bench scenarios show them. The bench uses a behavioural PHY that records all 64 bits of every frame and answers reads. The bench scenarios also cover these cases:
- a read to an absent PHY returning 0xFFFF;
- a Clause 22 address write sending nothing;
- the error flag clearing on the next frame.

// File: rtl/mdio_master.sv
module mdio_master (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int FRAME_LEN = 64;
  localparam int TA_IDX    = 46;
  localparam logic [5:0] LAST_IDX = 6'(FRAME_LEN - 1);

  logic [15:0] div_q, cnt_q, addr_q, data_q;
  logic [9:0]  ctrl_q;
  logic [63:0] frm_q;
  logic [5:0]  idx_q, idx_n;
  logic        c45_q, neg_q, busy_q, rderr_q, mdc_q, act_q, rd_q;
  logic        tick, rise, fall, drv, acc, go_addr, go_wr, go_rd, go;
  logic [1:0]  st, op;
  logic [4:0]  f_port, f_dev;

  assign tick    = (div_q != 16'd0) && (cnt_q >= div_q - 16'd1);
  assign rise    = tick & ~mdc_q;
  assign fall    = tick & mdc_q;
  assign drv     = neg_q ? fall : rise;
  assign acc     = wr_en & ~busy_q;
  assign go_addr = acc && addr == 2'd2 && c45_q;
  assign go_wr   = acc && addr == 2'd3;
  assign go_rd   = acc && addr == 2'd1 && wdata[15];
  assign go      = go_addr | go_wr | go_rd;
  assign st      = c45_q ? 2'b00 : 2'b01;
  assign op      = go_addr ? 2'b00 : go_wr ? 2'b01 : (c45_q ? 2'b11 : 2'b10);
  assign f_port  = go_rd ? wdata[9:5] : ctrl_q[9:5];
  assign f_dev   = go_rd ? wdata[4:0] : ctrl_q[4:0];
  assign idx_n   = idx_q + 6'd1;
  assign mdc     = mdc_q;

  always_comb begin
    case (addr)
      2'd0:    rdata = {div_q, 12'd0, neg_q, c45_q, rderr_q, busy_q};
      2'd1:    rdata = {22'd0, ctrl_q};
      2'd2:    rdata = {16'd0, addr_q};
      default: rdata = {16'd0, rderr_q ? 16'hFFFF : data_q};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (div_q == 16'd0) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 16'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0; c45_q <= 1'b0; neg_q <= 1'b1;
      ctrl_q <= '0; addr_q <= '0; data_q <= '0;
      busy_q <= 1'b0; rderr_q <= 1'b0; act_q <= 1'b0; rd_q <= 1'b0;
      idx_q <= '0; frm_q <= '0; mdio_o <= 1'b1; mdio_oe <= 1'b0;
    end else begin
      if (acc) begin
        case (addr)
          2'd0: begin c45_q <= wdata[2]; neg_q <= wdata[3]; div_q <= wdata[31:16]; end
          2'd1: ctrl_q <= wdata[9:0];
          2'd2: addr_q <= wdata[15:0];
          default: data_q <= wdata[15:0];
        endcase
      end
      if (go) begin
        busy_q  <= 1'b1;
        act_q   <= 1'b0;
        idx_q   <= '0;
        rd_q    <= go_rd;
        rderr_q <= 1'b0;
        frm_q   <= {32'hFFFF_FFFF, st, op, f_port, f_dev, 2'b10, wdata[15:0]};
      end else if (busy_q) begin
        if (rise && act_q && rd_q) begin
          if (idx_q == 6'd47 && mdio_i) rderr_q <= 1'b1;
          if (idx_q >= 6'd48) data_q <= {data_q[14:0], mdio_i};
        end
        if (drv) begin
          if (!act_q) begin
            act_q   <= 1'b1;
            mdio_o  <= frm_q[63];
            mdio_oe <= 1'b1;
          end else if (idx_q == LAST_IDX) begin
            busy_q  <= 1'b0;
            act_q   <= 1'b0;
            mdio_oe <= 1'b0;
          end else begin
            idx_q   <= idx_n;
            mdio_o  <= frm_q[~idx_n];
            mdio_oe <= !(rd_q && idx_n >= 6'(TA_IDX));
          end
        end
      end
    end
  end
endmodule

module mdio_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        busy_q,
  input logic        act_q,
  input logic        rd_q,
  input logic [5:0]  idx_q,
  input logic [15:0] div_q,
  input logic [9:0]  ctrl_q,
  input logic        mdc_q,
  input logic        mdio_o,
  input logic        mdio_oe
);
  // R2
  stopped_mdc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q == 16'd0) |=> !mdc_q);
  // R6
  read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && act_q && rd_q && idx_q >= 6'd46) |-> !mdio_oe);
  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !mdio_oe);
  // R8
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(wr_en));
  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && wr_en) |=> $stable(ctrl_q));
  // R10
  edge_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdio_o) |-> !$stable(mdc_q));
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .busy_q(busy_q), .act_q(act_q),
  .rd_q(rd_q), .idx_q(idx_q), .div_q(div_q), .ctrl_q(ctrl_q), .mdc_q(mdc_q),
  .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/mdio_master_tb.sv
`timescale 1ns/1ps
module mdio_master_tb;
  logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, mdio_i = 1'b1;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0, rdata;
  logic        mdc, mdio_o, mdio_oe;

  mdio_master u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
                     .rdata(rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, frames = 0, pos = -1, bad_edge = 0;
  logic [63:0] cap, capoe;
  logic mdc_prev = 1'b0, o_prev = 1'b1, oe_prev = 1'b0, phy_present = 1'b1, neg_exp = 1'b1;
  logic [15:0] phy_data = '0;

  // behavioural PHY: records the bit presented before each rising MDC edge
  always @(negedge clk) begin
    if (mdio_o !== o_prev && mdc !== (neg_exp ? 1'b0 : 1'b1)) bad_edge++;
    if (mdc && !mdc_prev) begin
      if (pos < 0 && oe_prev) pos = 0;
      if (pos >= 0) begin
        cap[63-pos] = o_prev;
        capoe[63-pos] = oe_prev;
        pos++;
        if (pos == 64) begin
          frames++;
          pos = -1;
          mdio_i = 1'b1;
        end else if (phy_present && cap[29] && pos == 47) mdio_i = 1'b0;
        else if (phy_present && cap[29] && pos >= 48) mdio_i = phy_data[63-pos];
        else mdio_i = 1'b1;
      end
    end
    mdc_prev = mdc; o_prev = mdio_o; oe_prev = mdio_oe;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; addr = 2'd0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic wait_idle;
    logic [31:0] s;
    rd(2'd0, s);
    while (s[0]) rd(2'd0, s);
    repeat (2) @(negedge clk);
  endtask

  // {c45, neg, kind(0 addr,1 write,2 read), phy present, port, dev, payload}
  localparam logic [30:0] VEC [9] = '{
    {1'b0, 1'b1, 2'd1, 1'b1, 5'h01, 5'h00, 16'hA5C3},
    {1'b0, 1'b1, 2'd2, 1'b1, 5'h1F, 5'h02, 16'h1234},
    {1'b0, 1'b0, 2'd2, 1'b0, 5'h03, 5'h11, 16'hBEEF},
    {1'b0, 1'b0, 2'd1, 1'b1, 5'h10, 5'h1F, 16'h0001},
    {1'b1, 1'b1, 2'd0, 1'b1, 5'h07, 5'h01, 16'h8001},
    {1'b1, 1'b1, 2'd1, 1'b1, 5'h07, 5'h01, 16'hFFFF},
    {1'b1, 1'b0, 2'd2, 1'b1, 5'h00, 5'h1E, 16'h0F0F},
    {1'b1, 1'b1, 2'd2, 1'b0, 5'h15, 5'h05, 16'h5555},
    {1'b1, 1'b0, 2'd0, 1'b1, 5'h1A, 5'h03, 16'h0000}
  };

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog: actual=hung expected=idle");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] r;
    int n, f0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(2'd0, r);
    chk(r == 32'h0000_0008, "R1 cfg reset", 64'(r), 64'h8);
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 line reset", {mdc, mdio_oe}, 64'h0);

    n = 0;
    repeat (50) begin @(negedge clk); if (mdc) n++; end
    chk(n == 0, "R2 div zero", 64'(n), 64'h0);
    wr(2'd0, {16'd3, 16'h0008});
    while (!mdc) @(negedge clk);
    n = 0;
    while (mdc) begin @(negedge clk); n++; end
    chk(n == 3, "R2 half period", 64'(n), 64'h3);

    foreach (VEC[i]) begin
      logic [30:0] v;
      logic [1:0] st, op;
      logic [63:0] exp;
      v = VEC[i];
      neg_exp = v[29];
      phy_present = v[26];
      phy_data = v[15:0];
      st = v[30] ? 2'b00 : 2'b01;
      op = (v[28:27] == 2'd0) ? 2'b00 : (v[28:27] == 2'd1) ? 2'b01 : (v[30] ? 2'b11 : 2'b10);
      exp = {32'hFFFF_FFFF, st, op, v[25:21], v[20:16], 2'b10, v[15:0]};
      wr(2'd0, {16'd2, 12'd0, v[29], v[30], 2'b00});
      wr(2'd1, {22'd0, v[25:21], v[20:16]});
      f0 = frames;
      bad_edge = 0;
      case (v[28:27])
        2'd0: wr(2'd2, {16'd0, v[15:0]});
        2'd1: wr(2'd3, {16'd0, v[15:0]});
        default: wr(2'd1, {16'd0, 1'b1, 5'd0, v[25:21], v[20:16]});
      endcase
      rd(2'd0, r);
      chk(r[0] == 1'b1, "R8 busy set", 64'(r[0]), 64'h1);
      wait_idle();
      chk(frames == f0 + 1, "R8 one frame", 64'(frames - f0), 64'h1);
      chk(bad_edge == 0, "R10 edge", 64'(bad_edge), 64'h0);
      if (v[28:27] == 2'd2) begin
        chk(cap[63:18] == exp[63:18], v[30] ? "R4 c45 read frame" : "R3 c22 read frame", cap, exp);
        chk(capoe == {{46{1'b1}}, 18'd0}, "R6 release", capoe, {{46{1'b1}}, 18'd0});
        rd(2'd3, r);
        chk(r[15:0] == (v[26] ? v[15:0] : 16'hFFFF), v[26] ? "R6 read data" : "R7 absent data",
            64'(r[15:0]), 64'(v[26] ? v[15:0] : 16'hFFFF));
      end else begin
        chk(cap == exp, v[30] ? "R4 c45 frame" : "R3 c22 frame", cap, exp);
        chk(capoe == '1, "R5 drive all", capoe, '1);
      end
      rd(2'd0, r);
      chk(r[1] == !v[26], "R7 error flag", 64'(r[1]), 64'(!v[26]));
    end

    wr(2'd0, {16'd2, 16'h0008});
    f0 = frames;
    wr(2'd2, 32'h4321);
    repeat (300) @(negedge clk);
    rd(2'd0, r);
    chk(frames == f0 && r[0] == 1'b0, "R4 c22 addr no frame", 64'(frames - f0), 64'h0);

    neg_exp = 1'b1;
    wr(2'd1, {22'd0, 5'h02, 5'h04});
    f0 = frames;
    wr(2'd3, 32'h1357);
    wr(2'd1, 32'h0000_83FF);
    wr(2'd3, 32'hAAAA);
    wr(2'd0, 32'h0000_0004);
    wait_idle();
    repeat (300) @(negedge clk);
    chk(frames == f0 + 1, "R9 no extra frame", 64'(frames - f0), 64'h1);
    rd(2'd1, r);
    chk(r[9:0] == 10'h044, "R9 ctrl kept", 64'(r), 64'h44);
    rd(2'd3, r);
    chk(r[15:0] == 16'h1357, "R9 data kept", 64'(r), 64'h1357);
    rd(2'd0, r);
    chk(r == {16'd2, 16'h0008}, "R9 cfg kept", 64'(r), 64'h0002_0008);

    summary();
    $finish;
  end
endmodule